// File: doc/BRIEF.md
# Relative Branch Next-IP Unit

This block decides where a 16-bit processor fetches next, once an instruction has been fetched and decoded. Each cycle that `in_valid` is high, it takes the instruction pointer that already points past the fetched instruction and an instruction class. It also takes a displacement, a condition selector, the current arithmetic flags and a return address supplied from the stack. One clock later it presents the next instruction pointer, whether control flow left the sequential path, and, for calls, a request to push the return address.

Two displacement widths are used. The unconditional jump and the call add a full 16-bit signed offset. Conditional jumps add only the low byte of the displacement, sign-extended, which gives a reach of -128 to +127 bytes. Conditions come in pairs, each with its negation. The set covers flag tests, unsigned magnitude tests and signed magnitude tests, so code that follows a compare can choose how the operands are read. Decoding the instruction and the stack memory are outside the block.

Top module: `nip_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset, `out_valid`, `taken`, `push_req`, `next_ip` and `push_addr` are all zero.
- R2: Outputs are registered one cycle after `in_valid`. A cycle with `in_valid` low gives `out_valid`, `taken` and `push_req` low on the next cycle, and `next_ip` keeps its previous value.
- R3: Class 0 (sequential) gives `next_ip` = `ip_post` and `taken` = 0.
- R4: Class 1 (jump) gives `next_ip` = `ip_post` + `disp` (16-bit signed) and `taken` = 1. For example, `ip_post` 0037h with `disp` 0010h gives 0047h.
- R5: Class 2 (conditional jump) uses only `disp[7:0]`, sign-extended to 16 bits, as the offset when the condition holds. `disp[15:8]` has no effect.
- R6: A conditional jump whose condition fails gives `next_ip` = `ip_post` and `taken` = 0.
- R7: `flags` bit 0 is CF, bit 1 is ZF, bit 2 is SF and bit 3 is OF. `cond[0]` negates the test selected by `cond[3:1]`. The base tests are: 0 = ZF (zero/equal), 1 = CF (below), 2 = CF|ZF (below-or-equal), 5 = SF, 6 = OF, 7 = always true. Negating 1 gives above-or-equal, and negating 2 gives above.
- R8: The signed base tests are 3 = SF!=OF (less) and 4 = ZF|(SF!=OF) (less-or-equal). Their negations are greater-or-equal and greater. After comparing 7FFFh with 8000h (flags 1101b), above fails and greater holds.
- R9: Class 3 (call) gives `next_ip` = `ip_post` + `disp`, with `taken` = 1, `push_req` = 1 and `push_addr` = `ip_post`.
- R10: Class 4 (return) gives `next_ip` = `ret_addr`, `taken` = 1 and `push_req` = 0.
- R11: All additions wrap modulo 2^16, both forward past FFFFh and backward past 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs hold a fetched instruction |
| op | input | 3 | Instruction class (0 seq, 1 jump, 2 cond jump, 3 call, 4 return) |
| ip_post | input | 16 | Instruction pointer past the fetched instruction |
| disp | input | 16 | Relative displacement |
| cond | input | 4 | Condition selector: base test in [3:1], negate in [0] |
| flags | input | 4 | {OF, SF, ZF, CF} |
| ret_addr | input | 16 | Return address popped from the stack |
| out_valid | output | 1 | Registered result valid |
| next_ip | output | 16 | Next instruction pointer |
| taken | output | 1 | Control left the sequential path |
| push_req | output | 1 | Push `push_addr` onto the stack |
| push_addr | output | 16 | Return address for a call |

## Verification
The bench compares 7FFFh with 8000h and checks both magnitude readings. A design that swapped the signed and unsigned tests would take the above branch and miss the greater one. Conditional jumps are given displacements whose upper byte holds junk and whose low byte is 80h. A design that used the full 16-bit field, or that zero-extended the byte, would land at the wrong address. Targets that wrap past FFFFh and below 0000h expose a carry that leaks out or is saturated. Calls and returns are checked for the pushed address and for a push request raised only on calls, and an idle cycle is checked to see that a stale result is not re-issued.

// File: rtl/nip_pkg.sv
package nip_pkg;
    typedef enum logic [2:0] {
        OP_SEQ  = 3'd0,
        OP_JMP  = 3'd1,
        OP_JCC  = 3'd2,
        OP_CALL = 3'd3,
        OP_RET  = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        TB_ZERO  = 3'd0,
        TB_CARRY = 3'd1,
        TB_BELEQ = 3'd2,
        TB_LESS  = 3'd3,
        TB_LSEQ  = 3'd4,
        TB_SIGN  = 3'd5,
        TB_OVFL  = 3'd6,
        TB_TRUE  = 3'd7
    } test_e;

    localparam int FL_CF = 0;
    localparam int FL_ZF = 1;
    localparam int FL_SF = 2;
    localparam int FL_OF = 3;
endpackage

// File: rtl/nip_cond.sv
module nip_cond
    import nip_pkg::*;
(
    input  logic [3:0] cond,
    input  logic [3:0] flags,
    output logic       hit
);
    logic cf, zf, sf, of, lt, base;

    always_comb begin
        cf = flags[FL_CF];
        zf = flags[FL_ZF];
        sf = flags[FL_SF];
        of = flags[FL_OF];
        lt = sf ^ of;
        unique case (test_e'(cond[3:1]))
            TB_ZERO:  base = zf;
            TB_CARRY: base = cf;
            TB_BELEQ: base = cf | zf;
            TB_LESS:  base = lt;
            TB_LSEQ:  base = zf | lt;
            TB_SIGN:  base = sf;
            TB_OVFL:  base = of;
            default:  base = 1'b1;
        endcase
        hit = base ^ cond[0];
    end
endmodule

// File: rtl/nip_target.sv
module nip_target #(
    parameter int IP_W    = 16,
    parameter int SHORT_W = 8
) (
    input  logic [IP_W-1:0] ip_post,
    input  logic [IP_W-1:0] disp,
    input  logic            short_sel,
    output logic [IP_W-1:0] target
);
    localparam int EXT_W = IP_W - SHORT_W;

    logic [IP_W-1:0] short_ext;
    logic [IP_W-1:0] offset;

    generate
        if (EXT_W > 0) begin : g_ext
            assign short_ext = {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
        end else begin : g_full
            assign short_ext = disp;
        end
    endgenerate

    always_comb begin
        offset = short_sel ? short_ext : disp;
        target = ip_post + offset;
    end
endmodule

// File: rtl/nip_unit.sv
module nip_unit
    import nip_pkg::*;
#(
    parameter int IP_W    = 16,
    parameter int SHORT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [2:0]      op,
    input  logic [IP_W-1:0] ip_post,
    input  logic [IP_W-1:0] disp,
    input  logic [3:0]      cond,
    input  logic [3:0]      flags,
    input  logic [IP_W-1:0] ret_addr,
    output logic            out_valid,
    output logic [IP_W-1:0] next_ip,
    output logic            taken,
    output logic            push_req,
    output logic [IP_W-1:0] push_addr
);
    typedef struct packed {
        logic            vld;
        logic [IP_W-1:0] nip;
        logic            tkn;
        logic            push;
        logic [IP_W-1:0] paddr;
    } state_t;

    state_t          st_d, st_q;
    logic            cond_hit;
    logic [IP_W-1:0] target;
    logic            is_short;

    assign is_short = (op_e'(op) == OP_JCC);

    nip_cond u_cond (
        .cond  (cond),
        .flags (flags),
        .hit   (cond_hit)
    );

    nip_target #(.IP_W(IP_W), .SHORT_W(SHORT_W)) u_target (
        .ip_post   (ip_post),
        .disp      (disp),
        .short_sel (is_short),
        .target    (target)
    );

    always_comb begin
        st_d       = st_q;
        st_d.vld   = in_valid;
        st_d.tkn   = 1'b0;
        st_d.push  = 1'b0;
        if (in_valid) begin
            unique case (op_e'(op))
                OP_JMP: begin
                    st_d.nip = target;
                    st_d.tkn = 1'b1;
                end
                OP_JCC: begin
                    st_d.nip = cond_hit ? target : ip_post;
                    st_d.tkn = cond_hit;
                end
                OP_CALL: begin
                    st_d.nip   = target;
                    st_d.tkn   = 1'b1;
                    st_d.push  = 1'b1;
                    st_d.paddr = ip_post;
                end
                OP_RET: begin
                    st_d.nip = ret_addr;
                    st_d.tkn = 1'b1;
                end
                default: st_d.nip = ip_post;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign next_ip   = st_q.nip;
    assign taken     = st_q.tkn;
    assign push_req  = st_q.push;
    assign push_addr = st_q.paddr;
endmodule

// File: rtl/nip_unit_chk.sv
module nip_unit_chk #(
    parameter int IP_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [2:0]      op,
    input logic [IP_W-1:0] ip_post,
    input logic [IP_W-1:0] ret_addr,
    input logic            out_valid,
    input logic [IP_W-1:0] next_ip,
    input logic            taken,
    input logic            push_req,
    input logic [IP_W-1:0] push_addr
);
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !taken && !push_req);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !taken && !push_req && $stable(next_ip));

    p_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd0) |=> (next_ip == $past(ip_post)) && !taken);

    p_call_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd3) |=> push_req && taken && (push_addr == $past(ip_post)));

    p_ret_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd4) |=> (next_ip == $past(ret_addr)) && taken && !push_req);
endmodule

bind nip_unit nip_unit_chk #(.IP_W(IP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .ip_post   (ip_post),
    .ret_addr  (ret_addr),
    .out_valid (out_valid),
    .next_ip   (next_ip),
    .taken     (taken),
    .push_req  (push_req),
    .push_addr (push_addr)
);

// File: tb/nip_unit_test.sv
module nip_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [15:0] ip_post = '0;
    logic [15:0] disp = '0;
    logic [3:0]  cond = '0;
    logic [3:0]  flags = '0;
    logic [15:0] ret_addr = '0;
    logic        out_valid;
    logic [15:0] next_ip;
    logic        taken;
    logic        push_req;
    logic [15:0] push_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    nip_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .ip_post(ip_post), .disp(disp), .cond(cond), .flags(flags),
        .ret_addr(ret_addr), .out_valid(out_valid), .next_ip(next_ip),
        .taken(taken), .push_req(push_req), .push_addr(push_addr)
    );

    // {op, ip_post, disp, cond, flags{OF,SF,ZF,CF}, ret_addr, exp_ip, exp_taken, exp_push}
    localparam int NV = 24;
    localparam logic [76:0] VEC [NV] = '{
        {3'd1, 16'h0037, 16'h0010, 4'd0,  4'b0000, 16'h0000, 16'h0047, 1'b1, 1'b0}, // R4
        {3'd1, 16'h0100, 16'hFF00, 4'd0,  4'b0000, 16'h0000, 16'h0000, 1'b1, 1'b0}, // R4 R11
        {3'd1, 16'hFFF0, 16'h0020, 4'd0,  4'b0000, 16'h0000, 16'h0010, 1'b1, 1'b0}, // R11
        {3'd0, 16'h1234, 16'h7777, 4'd14, 4'b1111, 16'hAAAA, 16'h1234, 1'b0, 1'b0}, // R3
        {3'd2, 16'h0200, 16'h007F, 4'd0,  4'b0010, 16'h0000, 16'h027F, 1'b1, 1'b0}, // R7 zero
        {3'd2, 16'h0200, 16'h007F, 4'd0,  4'b0000, 16'h0000, 16'h0200, 1'b0, 1'b0}, // R6
        {3'd2, 16'h0200, 16'hAB80, 4'd1,  4'b0000, 16'h0000, 16'h0180, 1'b1, 1'b0}, // R5 not-zero
        {3'd2, 16'h0300, 16'h0010, 4'd5,  4'b1101, 16'h0000, 16'h0300, 1'b0, 1'b0}, // R8 above fails
        {3'd2, 16'h0300, 16'h0010, 4'd9,  4'b1101, 16'h0000, 16'h0310, 1'b1, 1'b0}, // R8 greater holds
        {3'd2, 16'h0400, 16'h00FE, 4'd4,  4'b0010, 16'h0000, 16'h03FE, 1'b1, 1'b0}, // R7 below-eq
        {3'd2, 16'h0400, 16'h0002, 4'd6,  4'b0100, 16'h0000, 16'h0402, 1'b1, 1'b0}, // R8 less
        {3'd2, 16'h0400, 16'h0002, 4'd7,  4'b0100, 16'h0000, 16'h0400, 1'b0, 1'b0}, // R8 ge fails
        {3'd2, 16'h0400, 16'h0002, 4'd8,  4'b1100, 16'h0000, 16'h0400, 1'b0, 1'b0}, // R8 le fails
        {3'd2, 16'h0500, 16'h0005, 4'd3,  4'b0001, 16'h0000, 16'h0500, 1'b0, 1'b0}, // R7 ae fails
        {3'd2, 16'h0500, 16'h0005, 4'd2,  4'b0001, 16'h0000, 16'h0505, 1'b1, 1'b0}, // R7 below
        {3'd2, 16'h0500, 16'h0010, 4'd14, 4'b0000, 16'h0000, 16'h0510, 1'b1, 1'b0}, // R7 always
        {3'd2, 16'h0500, 16'h0010, 4'd15, 4'b0000, 16'h0000, 16'h0500, 1'b0, 1'b0}, // R7 never
        {3'd2, 16'h0500, 16'h0010, 4'd10, 4'b0100, 16'h0000, 16'h0510, 1'b1, 1'b0}, // R7 sign
        {3'd2, 16'h0500, 16'h0010, 4'd12, 4'b0000, 16'h0000, 16'h0500, 1'b0, 1'b0}, // R7 overflow
        {3'd2, 16'hFFFE, 16'h0005, 4'd14, 4'b0000, 16'h0000, 16'h0003, 1'b1, 1'b0}, // R11
        {3'd2, 16'h0005, 16'h00F0, 4'd14, 4'b0000, 16'h0000, 16'hFFF5, 1'b1, 1'b0}, // R11 R5
        {3'd3, 16'h0040, 16'h0100, 4'd0,  4'b0000, 16'h9999, 16'h0140, 1'b1, 1'b1}, // R9
        {3'd4, 16'h0050, 16'h0100, 4'd0,  4'b0000, 16'h1234, 16'h1234, 1'b1, 1'b0}, // R10
        {3'd1, 16'h0037, 16'h8000, 4'd0,  4'b0000, 16'h0000, 16'h8037, 1'b1, 1'b0}  // R4
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] o, input logic [15:0] ip, input logic [15:0] d,
                         input logic [3:0] c, input logic [3:0] f, input logic [15:0] r);
        @(negedge clk);
        in_valid = 1'b1; op = o; ip_post = ip; disp = d; cond = c; flags = f; ret_addr = r;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 out_valid", 16'(out_valid), 16'h0);
        check("R1 next_ip", next_ip, 16'h0);
        check("R1 taken/push", 16'({taken, push_req}), 16'h0);
        check("R1 push_addr", push_addr, 16'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [76:0] v;
            v = VEC[i];
            drive(v[76:74], v[73:58], v[57:42], v[41:38], v[37:34], v[33:18]);
            check($sformatf("vec %0d next_ip (R3-R11 table)", i), next_ip, v[17:2]);
            check($sformatf("vec %0d taken", i), 16'(taken), 16'(v[1]));
            check($sformatf("vec %0d push_req R9", i), 16'(push_req), 16'(v[0]));
            check($sformatf("vec %0d out_valid R2", i), 16'(out_valid), 16'h1);
            if (v[0]) check("R9 push_addr", push_addr, v[73:58]);
        end

        // R2: idle cycle holds next_ip and drops strobes
        @(negedge clk);
        check("R2 idle out_valid", 16'(out_valid), 16'h0);
        check("R2 idle next_ip held", next_ip, 16'h8037);
        check("R2 idle taken/push", 16'({taken, push_req}), 16'h0);

        // R5: upper displacement byte ignored for conditional jump
        drive(3'd2, 16'h1000, 16'h7F80, 4'd14, 4'b0000, 16'h0);
        check("R5 upper byte ignored", next_ip, 16'h0F80);

        // R1: reset mid-stream clears outputs
        drive(3'd3, 16'h2222, 16'h0002, 4'd0, 4'b0000, 16'h0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears next_ip", next_ip, 16'h0);
        check("R1 reset clears push", 16'({push_req, out_valid}), 16'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule